// File: doc/BRIEF.md
# Remote Miss Cache

This block sits beside a cluster's local bus. It watches processor requests whose addresses belong to memory homed in another cluster, and it keeps copies of those remote lines in a direct-mapped array of 16-byte lines. Every entry serves two purposes. It is a cache line holding a tag, a coherence state and the data. It is also the miss-status holder for a request that is still travelling through the network. Because of this, several remote misses to different entries can be outstanding at the same time.

On a snooped request the block does one of three things. It serves the request from its own copy, it issues a network request and marks the entry pending, or it refuses the request with a retry response because the entry is busy with an earlier request. Data replies and invalidation acknowledgements come back from the network tagged with the line address. An exclusive request completes only when its data has arrived and every acknowledgement it was told to expect has been counted. Acknowledgements may arrive before the data. When an entry finishes, the block signals completion to the bus side together with the line. A dirty line that is displaced by a new miss is handed out for write-back.

Top module: `rmt_miss_cache`

## Requirements
- R1: After reset every entry is invalid, and all output valid strobes are low.
- R2: A bus request with `bus_req_remote` low gets no response, no network request and no write-back, and it leaves every entry unchanged.
- R3: A remote request is a miss when its entry is invalid, holds another tag, or holds the same tag in the shared state while exclusive access is asked for. On a miss, one cycle later the block gives response kind 2 (MISS) together with a network request. That request carries the line-aligned address (offset bits zero) and the exclusive flag. The entry becomes pending-read, or pending-exclusive if the request was exclusive.
- R4: A remote request to an entry that is pending, whatever its tag, gets response kind 3 (RETRY) one cycle later. It issues no network request and causes no write-back.
- R5: A data reply (`rep_is_ack`=0) whose address matches a pending-read entry moves that entry to shared and stores the line. One cycle later it raises `done_valid` with the line address, `done_excl`=0 and the reply data.
- R6: A pending-exclusive entry adds the reply's `rep_acks` value when its data arrives, and subtracts one for each ack (`rep_is_ack`=1). It becomes dirty and signals done with `done_excl`=1 only in the cycle after data has arrived and the count is zero, whatever order the messages arrive in.
- R7: A remote read that hits a shared or dirty entry, or an exclusive request that hits a dirty entry, gets response kind 1 (HIT) with the stored line one cycle later, and no network request.
- R8: An exclusive request that hits a shared entry is treated as an upgrade miss: a MISS response and a network request with the exclusive flag set.
- R9: A miss that displaces a dirty line raises `wb_valid` together with the network request, carrying the victim's line address and data. Displacing a shared line raises no write-back.
- R10: A reply whose address does not match a pending entry is ignored. So is an ack addressed to a pending-read entry. Neither changes any state, and neither raises `done_valid`.
- R11: Entries with different indices can be pending at the same time, and they complete in whatever order their replies arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req_valid | input | 1 | Snooped bus request present |
| bus_req_addr | input | ADDR_W | Byte address of the request |
| bus_req_excl | input | 1 | Request needs exclusive ownership |
| bus_req_remote | input | 1 | Address is homed in another cluster |
| bus_rsp_valid | output | 1 | Response to the request of the previous cycle |
| bus_rsp_kind | output | 2 | 1 HIT, 2 MISS, 3 RETRY |
| bus_rsp_line | output | 8*LINE_BYTES | Line data on HIT |
| net_req_valid | output | 1 | Issue a request to the network |
| net_req_addr | output | ADDR_W | Line-aligned request address |
| net_req_excl | output | 1 | Network request is for exclusive ownership |
| wb_valid | output | 1 | Dirty victim write-back |
| wb_addr | output | ADDR_W | Victim line address |
| wb_line | output | 8*LINE_BYTES | Victim data |
| rep_valid | input | 1 | Network reply present |
| rep_is_ack | input | 1 | 1 invalidation ack, 0 data reply |
| rep_addr | input | ADDR_W | Line address of the reply |
| rep_acks | input | ACK_W | Number of acks to expect (data replies) |
| rep_line | input | 8*LINE_BYTES | Reply data |
| done_valid | output | 1 | An entry finished its pending request |
| done_addr | output | ADDR_W | Finished line address |
| done_excl | output | 1 | The finished request was exclusive |
| done_line | output | 8*LINE_BYTES | Line data of the finished entry |

## Verification
Every output of the block comes from a single register stage. The response, the network request and any write-back for a bus request are due exactly one cycle after the edge that captured the request. A completion is due one cycle after the edge that captured the reply that finished it. The bench drives each stimulus on a falling edge, holds it through exactly one rising edge and samples the outputs 1 ns after that edge. It then checks that the next stimulus leaves the strobes low when nothing should happen. Ack ordering is swept over every expected count from 0 to 3, and each index of a four-entry configuration is driven through miss, retry, ignored replies and hit.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

    typedef enum logic [2:0] {
        ST_INV = 3'd0,
        ST_PRD = 3'd1,
        ST_PEX = 3'd2,
        ST_SHR = 3'd3,
        ST_DRT = 3'd4
    } ent_state_e;

    localparam logic [1:0] RSP_NONE  = 2'd0;
    localparam logic [1:0] RSP_HIT   = 2'd1;
    localparam logic [1:0] RSP_MISS  = 2'd2;
    localparam logic [1:0] RSP_RETRY = 2'd3;

endpackage

// File: rtl/rmc_addr_split.sv
module rmc_addr_split #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int LINES      = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(LINES),
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag,
    output logic [ADDR_W-1:0] aligned
);

    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

    always_comb begin
        aligned = addr & ~OFF_MASK;
        idx     = aligned[OFF_W +: IDX_W];
        tag     = aligned[ADDR_W-1 -: TAG_W];
    end

endmodule

// File: rtl/rmc_ack_tracker.sv
module rmc_ack_tracker
    import rmc_pkg::*;
#(
    parameter int ACK_W = 4,
    localparam int CNT_W = ACK_W + 1
) (
    input  ent_state_e              cur_st,
    input  logic signed [CNT_W-1:0] cur_cnt,
    input  logic                    cur_got,
    input  logic                    rep_data,
    input  logic                    rep_ack,
    input  logic [ACK_W-1:0]        rep_acks,
    output ent_state_e              nxt_st,
    output logic signed [CNT_W-1:0] nxt_cnt,
    output logic                    nxt_got,
    output logic                    take_data,
    output logic                    finish
);

    logic signed [CNT_W-1:0] add_v;
    logic signed [CNT_W-1:0] sub_v;
    logic signed [CNT_W-1:0] cnt_tmp;
    logic                    got_tmp;

    always_comb begin
        add_v     = rep_data ? $signed({1'b0, rep_acks}) : '0;
        sub_v     = rep_ack ? CNT_W'(1) : '0;
        cnt_tmp   = cur_cnt + add_v - sub_v;
        got_tmp   = cur_got | rep_data;
        nxt_st    = cur_st;
        nxt_cnt   = cur_cnt;
        nxt_got   = cur_got;
        take_data = 1'b0;
        finish    = 1'b0;
        case (cur_st)
            ST_PRD: begin
                if (rep_data) begin
                    take_data = 1'b1;
                    nxt_st    = ST_SHR;
                    finish    = 1'b1;
                end
            end
            ST_PEX: begin
                take_data = rep_data;
                nxt_got   = got_tmp;
                if (got_tmp && cnt_tmp == '0) begin
                    nxt_st  = ST_DRT;
                    nxt_cnt = '0;
                    finish  = 1'b1;
                end else begin
                    nxt_cnt = cnt_tmp;
                end
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/rmc_entry_array.sv
module rmc_entry_array
    import rmc_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int TAG_W  = 24,
    parameter int CNT_W  = 5,
    parameter int DATA_W = 128,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        rd_a_idx,
    output ent_state_e              rd_a_st,
    output logic [TAG_W-1:0]        rd_a_tag,
    output logic [DATA_W-1:0]       rd_a_line,
    input  logic [IDX_W-1:0]        rd_b_idx,
    output ent_state_e              rd_b_st,
    output logic [TAG_W-1:0]        rd_b_tag,
    output logic signed [CNT_W-1:0] rd_b_cnt,
    output logic                    rd_b_got,
    output logic [DATA_W-1:0]       rd_b_line,
    input  logic                    alloc_en,
    input  logic [IDX_W-1:0]        alloc_idx,
    input  ent_state_e              alloc_st,
    input  logic [TAG_W-1:0]        alloc_tag,
    input  logic                    upd_en,
    input  logic [IDX_W-1:0]        upd_idx,
    input  ent_state_e              upd_st,
    input  logic signed [CNT_W-1:0] upd_cnt,
    input  logic                    upd_got,
    input  logic                    upd_line_en,
    input  logic [DATA_W-1:0]       upd_line
);

    typedef struct packed {
        ent_state_e              st;
        logic [TAG_W-1:0]        tag;
        logic signed [CNT_W-1:0] cnt;
        logic                    got;
        logic [DATA_W-1:0]       line;
    } ent_t;

    ent_t all_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_ent
        ent_t e_d;
        ent_t e_q;

        always_comb begin
            e_d = e_q;
            if (alloc_en && alloc_idx == IDX_W'(g)) begin
                e_d.st  = alloc_st;
                e_d.tag = alloc_tag;
                e_d.cnt = '0;
                e_d.got = 1'b0;
            end
            if (upd_en && upd_idx == IDX_W'(g)) begin
                e_d.st  = upd_st;
                e_d.cnt = upd_cnt;
                e_d.got = upd_got;
                if (upd_line_en) begin
                    e_d.line = upd_line;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_q <= '0;
            end else begin
                e_q <= e_d;
            end
        end

        assign all_q[g] = e_q;
    end

    always_comb begin
        rd_a_st   = all_q[rd_a_idx].st;
        rd_a_tag  = all_q[rd_a_idx].tag;
        rd_a_line = all_q[rd_a_idx].line;
        rd_b_st   = all_q[rd_b_idx].st;
        rd_b_tag  = all_q[rd_b_idx].tag;
        rd_b_cnt  = all_q[rd_b_idx].cnt;
        rd_b_got  = all_q[rd_b_idx].got;
        rd_b_line = all_q[rd_b_idx].line;
    end

    AST_PORTS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && upd_en) |-> (alloc_idx != upd_idx)); // R4

endmodule

// File: rtl/rmt_miss_cache.sv
module rmt_miss_cache
    import rmc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINES      = 16,
    parameter int LINE_BYTES = 16,
    parameter int ACK_W      = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_req_valid,
    input  logic [ADDR_W-1:0]         bus_req_addr,
    input  logic                      bus_req_excl,
    input  logic                      bus_req_remote,
    output logic                      bus_rsp_valid,
    output logic [1:0]                bus_rsp_kind,
    output logic [8*LINE_BYTES-1:0]   bus_rsp_line,
    output logic                      net_req_valid,
    output logic [ADDR_W-1:0]         net_req_addr,
    output logic                      net_req_excl,
    output logic                      wb_valid,
    output logic [ADDR_W-1:0]         wb_addr,
    output logic [8*LINE_BYTES-1:0]   wb_line,
    input  logic                      rep_valid,
    input  logic                      rep_is_ack,
    input  logic [ADDR_W-1:0]         rep_addr,
    input  logic [ACK_W-1:0]          rep_acks,
    input  logic [8*LINE_BYTES-1:0]   rep_line,
    output logic                      done_valid,
    output logic [ADDR_W-1:0]         done_addr,
    output logic                      done_excl,
    output logic [8*LINE_BYTES-1:0]   done_line
);

    localparam int DATA_W = 8 * LINE_BYTES;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int CNT_W  = ACK_W + 1;

    typedef struct packed {
        logic              rsp_v;
        logic [1:0]        rsp_k;
        logic [DATA_W-1:0] rsp_line;
        logic              net_v;
        logic [ADDR_W-1:0] net_addr;
        logic              net_x;
        logic              wb_v;
        logic [ADDR_W-1:0] wb_addr;
        logic [DATA_W-1:0] wb_line;
        logic              done_v;
        logic [ADDR_W-1:0] done_addr;
        logic              done_x;
        logic [DATA_W-1:0] done_line;
    } out_t;

    out_t out_d, out_q;

    logic [IDX_W-1:0]        bus_idx, rep_idx;
    logic [TAG_W-1:0]        bus_tag, rep_tag;
    logic [ADDR_W-1:0]       bus_aligned, rep_aligned;

    ent_state_e              a_st, b_st;
    logic [TAG_W-1:0]        a_tag, b_tag;
    logic [DATA_W-1:0]       a_line, b_line;
    logic signed [CNT_W-1:0] b_cnt;
    logic                    b_got;

    logic                    alloc_en_d;
    ent_state_e              alloc_st_d;
    logic                    rep_match;
    logic                    rep_data_hit, rep_ack_hit;

    ent_state_e              trk_st;
    logic signed [CNT_W-1:0] trk_cnt;
    logic                    trk_got, trk_take, trk_finish;

    logic                    bus_go, a_pending, a_tag_hit, a_serves;

    rmc_addr_split #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LINES(LINES)) u_bus_split (
        .addr(bus_req_addr), .idx(bus_idx), .tag(bus_tag), .aligned(bus_aligned)
    );

    rmc_addr_split #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LINES(LINES)) u_rep_split (
        .addr(rep_addr), .idx(rep_idx), .tag(rep_tag), .aligned(rep_aligned)
    );

    rmc_entry_array #(.LINES(LINES), .TAG_W(TAG_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_a_idx   (bus_idx),
        .rd_a_st    (a_st),
        .rd_a_tag   (a_tag),
        .rd_a_line  (a_line),
        .rd_b_idx   (rep_idx),
        .rd_b_st    (b_st),
        .rd_b_tag   (b_tag),
        .rd_b_cnt   (b_cnt),
        .rd_b_got   (b_got),
        .rd_b_line  (b_line),
        .alloc_en   (alloc_en_d),
        .alloc_idx  (bus_idx),
        .alloc_st   (alloc_st_d),
        .alloc_tag  (bus_tag),
        .upd_en     (rep_match),
        .upd_idx    (rep_idx),
        .upd_st     (trk_st),
        .upd_cnt    (trk_cnt),
        .upd_got    (trk_got),
        .upd_line_en(trk_take),
        .upd_line   (rep_line)
    );

    rmc_ack_tracker #(.ACK_W(ACK_W)) u_tracker (
        .cur_st   (b_st),
        .cur_cnt  (b_cnt),
        .cur_got  (b_got),
        .rep_data (rep_data_hit),
        .rep_ack  (rep_ack_hit),
        .rep_acks (rep_acks),
        .nxt_st   (trk_st),
        .nxt_cnt  (trk_cnt),
        .nxt_got  (trk_got),
        .take_data(trk_take),
        .finish   (trk_finish)
    );

    always_comb begin
        // Bus side: only entries that are not pending are ever allocated here.
        bus_go     = bus_req_valid && bus_req_remote;
        a_pending  = (a_st == ST_PRD) || (a_st == ST_PEX);
        a_tag_hit  = (a_tag == bus_tag);
        a_serves   = a_tag_hit && ((a_st == ST_DRT) || (a_st == ST_SHR && !bus_req_excl));
        alloc_en_d = 1'b0;
        alloc_st_d = bus_req_excl ? ST_PEX : ST_PRD;

        // Reply side: only pending entries are ever updated here.
        rep_match    = rep_valid && (b_tag == rep_tag) && ((b_st == ST_PRD) || (b_st == ST_PEX));
        rep_data_hit = rep_match && !rep_is_ack;
        rep_ack_hit  = rep_match && rep_is_ack;

        out_d        = out_q;
        out_d.rsp_v  = 1'b0;
        out_d.rsp_k  = RSP_NONE;
        out_d.net_v  = 1'b0;
        out_d.wb_v   = 1'b0;
        out_d.done_v = 1'b0;

        if (bus_go) begin
            out_d.rsp_v = 1'b1;
            if (a_pending) begin
                out_d.rsp_k = RSP_RETRY;
            end else if (a_serves) begin
                out_d.rsp_k    = RSP_HIT;
                out_d.rsp_line = a_line;
            end else begin
                out_d.rsp_k    = RSP_MISS;
                out_d.net_v    = 1'b1;
                out_d.net_addr = bus_aligned;
                out_d.net_x    = bus_req_excl;
                alloc_en_d     = 1'b1;
                if (a_st == ST_DRT) begin
                    out_d.wb_v    = 1'b1;
                    out_d.wb_addr = {a_tag, bus_idx, {OFF_W{1'b0}}};
                    out_d.wb_line = a_line;
                end
            end
        end

        if (trk_finish) begin
            out_d.done_v    = 1'b1;
            out_d.done_addr = rep_aligned;
            out_d.done_x    = (b_st == ST_PEX);
            out_d.done_line = trk_take ? rep_line : b_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign bus_rsp_valid = out_q.rsp_v;
    assign bus_rsp_kind  = out_q.rsp_k;
    assign bus_rsp_line  = out_q.rsp_line;
    assign net_req_valid = out_q.net_v;
    assign net_req_addr  = out_q.net_addr;
    assign net_req_excl  = out_q.net_x;
    assign wb_valid      = out_q.wb_v;
    assign wb_addr       = out_q.wb_addr;
    assign wb_line       = out_q.wb_line;
    assign done_valid    = out_q.done_v;
    assign done_addr     = out_q.done_addr;
    assign done_excl     = out_q.done_x;
    assign done_line     = out_q.done_line;

    AST_RSP_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_remote) |=> bus_rsp_valid); // R3

    AST_LOCAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req_valid && bus_req_remote) |=> !(bus_rsp_valid || net_req_valid || wb_valid)); // R2

    AST_NET_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        net_req_valid |-> (bus_rsp_valid && bus_rsp_kind == RSP_MISS)); // R3

    AST_RETRY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rsp_valid && bus_rsp_kind == RSP_RETRY) |-> !(net_req_valid || wb_valid)); // R4

    AST_WB_WITH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> net_req_valid); // R9

    AST_DONE_AFTER_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !rep_valid |=> !done_valid); // R10

endmodule

// File: tb/rmt_miss_cache_test.sv
module rmt_miss_cache_test;

    localparam int AW = 16;
    localparam int NL = 4;
    localparam int LB = 16;
    localparam int AK = 4;
    localparam int DW = 8 * LB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req_valid = 1'b0;
    logic [AW-1:0] bus_req_addr = '0;
    logic          bus_req_excl = 1'b0;
    logic          bus_req_remote = 1'b0;
    logic          bus_rsp_valid;
    logic [1:0]    bus_rsp_kind;
    logic [DW-1:0] bus_rsp_line;
    logic          net_req_valid;
    logic [AW-1:0] net_req_addr;
    logic          net_req_excl;
    logic          wb_valid;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_line;
    logic          rep_valid = 1'b0;
    logic          rep_is_ack = 1'b0;
    logic [AW-1:0] rep_addr = '0;
    logic [AK-1:0] rep_acks = '0;
    logic [DW-1:0] rep_line = '0;
    logic          done_valid;
    logic [AW-1:0] done_addr;
    logic          done_excl;
    logic [DW-1:0] done_line;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rmt_miss_cache #(.ADDR_W(AW), .LINES(NL), .LINE_BYTES(LB), .ACK_W(AK)) uut (.*);

    function automatic logic [AW-1:0] mk(input int tag, input int idx);
        return AW'((tag << 6) | (idx << 4));
    endfunction

    function automatic logic [DW-1:0] ln(input logic [AW-1:0] a, input int salt);
        return {8{a ^ 16'h5a5a ^ 16'(salt)}};
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic [AW-1:0] a, input logic ex, input logic rm);
        @(negedge clk);
        bus_req_valid = 1'b1; bus_req_addr = a; bus_req_excl = ex; bus_req_remote = rm;
        @(posedge clk); #1;
        bus_req_valid = 1'b0;
    endtask

    task automatic rep_op(input logic [AW-1:0] a, input logic ack, input int n, input logic [DW-1:0] d);
        @(negedge clk);
        rep_valid = 1'b1; rep_addr = a; rep_is_ack = ack; rep_acks = AK'(n); rep_line = d;
        @(posedge clk); #1;
        rep_valid = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: strobes idle after reset
        chk("R1 rsp", DW'(bus_rsp_valid), 0);
        chk("R1 net", DW'(net_req_valid), 0);
        chk("R1 wb", DW'(wb_valid), 0);
        chk("R1 done", DW'(done_valid), 0);

        // R3 / R1: every index starts invalid, so reads miss
        for (int i = 0; i < NL; i++) begin
            bus_op(mk(16'h100 + i, i) | 16'h5, 1'b0, 1'b1);
            chk("R3 kind", DW'(bus_rsp_kind), 2);
            chk("R3 net", DW'(net_req_valid), 1);
            chk("R3 addr", DW'(net_req_addr), DW'(mk(16'h100 + i, i)));
            chk("R3 excl", DW'(net_req_excl), 0);
            chk("R9 no wb on invalid", DW'(wb_valid), 0);
        end
        // R4: conflicts refused while pending
        for (int i = 0; i < NL; i++) begin
            bus_op(mk(16'h200, i), 1'b0, 1'b1);
            chk("R4 kind", DW'(bus_rsp_kind), 3);
            chk("R4 net", DW'(net_req_valid), 0);
        end
        // R2: local-home requests ignored
        for (int i = 0; i < NL; i++) begin
            bus_op(mk(16'h300, i), 1'b1, 1'b0);
            chk("R2 rsp", DW'(bus_rsp_valid), 0);
            chk("R2 net", DW'(net_req_valid), 0);
        end
        // R10: wrong-tag data and ack to pending-read ignored
        for (int i = 0; i < NL; i++) begin
            rep_op(mk(16'h200, i), 1'b0, 0, ln(mk(16'h200, i), 0));
            chk("R10 wrong tag", DW'(done_valid), 0);
            rep_op(mk(16'h100 + i, i), 1'b1, 0, '0);
            chk("R10 ack to read", DW'(done_valid), 0);
        end
        // R5 / R11: complete in reverse order
        for (int i = NL - 1; i >= 0; i--) begin
            rep_op(mk(16'h100 + i, i), 1'b0, 0, ln(mk(16'h100 + i, i), 0));
            chk("R11 done", DW'(done_valid), 1);
            chk("R5 addr", DW'(done_addr), DW'(mk(16'h100 + i, i)));
            chk("R5 excl", DW'(done_excl), 0);
            chk("R5 line", done_line, ln(mk(16'h100 + i, i), 0));
        end
        // R7: shared hits
        for (int i = 0; i < NL; i++) begin
            bus_op(mk(16'h100 + i, i), 1'b0, 1'b1);
            chk("R7 kind", DW'(bus_rsp_kind), 1);
            chk("R7 line", bus_rsp_line, ln(mk(16'h100 + i, i), 0));
            chk("R7 net", DW'(net_req_valid), 0);
        end
        // R8 upgrade, R6 ack before data
        bus_op(mk(16'h100, 0), 1'b1, 1'b1);
        chk("R8 kind", DW'(bus_rsp_kind), 2);
        chk("R8 excl", DW'(net_req_excl), 1);
        bus_op(mk(16'h100, 0), 1'b0, 1'b1);
        chk("R4 pending excl", DW'(bus_rsp_kind), 3);
        rep_op(mk(16'h100, 0), 1'b1, 0, '0);
        chk("R6 early ack", DW'(done_valid), 0);
        rep_op(mk(16'h100, 0), 1'b0, 2, ln(mk(16'h100, 0), 7));
        chk("R6 data one owed", DW'(done_valid), 0);
        rep_op(mk(16'h100, 0), 1'b1, 0, '0);
        chk("R6 done", DW'(done_valid), 1);
        chk("R6 excl", DW'(done_excl), 1);
        chk("R6 line", done_line, ln(mk(16'h100, 0), 7));
        bus_op(mk(16'h100, 0), 1'b0, 1'b1);
        chk("R7 dirty read", DW'(bus_rsp_kind), 1);
        chk("R7 dirty line", bus_rsp_line, ln(mk(16'h100, 0), 7));
        bus_op(mk(16'h100, 0), 1'b1, 1'b1);
        chk("R7 dirty excl", DW'(bus_rsp_kind), 1);
        // R6: zero acks finishes on data
        bus_op(mk(16'h101, 1), 1'b1, 1'b1);
        rep_op(mk(16'h101, 1), 1'b0, 0, ln(mk(16'h101, 1), 3));
        chk("R6 zero acks", DW'(done_valid), 1);
        chk("R6 zero acks excl", DW'(done_excl), 1);
        // R2: local request cannot evict
        bus_op(mk(16'h3ff, 1), 1'b1, 1'b0);
        chk("R2 quiet", DW'(bus_rsp_valid), 0);
        bus_op(mk(16'h101, 1), 1'b0, 1'b1);
        chk("R2 state kept", DW'(bus_rsp_kind), 1);
        // R9: dirty victim written back, shared victim not
        bus_op(mk(16'h150, 0), 1'b0, 1'b1);
        chk("R9 miss", DW'(bus_rsp_kind), 2);
        chk("R9 wb", DW'(wb_valid), 1);
        chk("R9 wb addr", DW'(wb_addr), DW'(mk(16'h100, 0)));
        chk("R9 wb line", wb_line, ln(mk(16'h100, 0), 7));
        bus_op(mk(16'h150, 2), 1'b0, 1'b1);
        chk("R9 shared victim", DW'(wb_valid), 0);
        rep_op(mk(16'h150, 0), 1'b1, 0, '0);
        chk("R10 stray ack", DW'(done_valid), 0);
        rep_op(mk(16'h150, 0), 1'b0, 0, ln(mk(16'h150, 0), 1));
        chk("R5 after replace", DW'(done_valid), 1);
        // R6 sweep of expected counts on index 3
        for (int n = 0; n < 4; n++) begin
            bus_op(mk(16'h180 + n, 3), 1'b1, 1'b1);
            chk("R6 sweep miss", DW'(bus_rsp_kind), 2);
            rep_op(mk(16'h180 + n, 3), 1'b0, n, ln(mk(16'h180 + n, 3), n));
            chk("R6 sweep data", DW'(done_valid), DW'(n == 0));
            for (int k = 1; k <= n; k++) begin
                rep_op(mk(16'h180 + n, 3), 1'b1, 0, '0);
                chk("R6 sweep ack", DW'(done_valid), DW'(k == n));
            end
        end
        summary();
    end

endmodule